// File: doc/BRIEF.md
# BCD Time-of-Day and Calendar Counter

This block keeps wall-clock time and a calendar in packed BCD: seconds, minutes, hours, a day-of-week count, day of month, month and a two-digit year. A prescaler divides the core clock down to a one-second tick. The prescaler runs only while an active-low run control is held low. Each tick moves the seconds forward and carries up through the chain. Month lengths and leap years are resolved on the fly from the current month and year.

Hours are kept in one byte that carries its own format. Bit 6 chooses the 12-hour form. Bit 5 is then either an afternoon flag or the upper tens-of-hours bit. A simple write port loads any single field. Loading the seconds field also restarts the prescaler, so software can align the second boundary. A one-cycle update strobe marks each clock update, so that neighbouring logic can sample a coherent set of fields.

Top module: `bcd_calendar_clock`

## Requirements
- R1: After reset, seconds, minutes, hours and year read 00, while day of week, day of month and month read 01. The update strobe is low.
- R2: While `osc_en_n` is 0, an update happens once every `TICK_DIV` clock cycles. `upd` is high for exactly one cycle, and in that cycle the outputs already show the new time.
- R3: While `osc_en_n` is 1, no field changes except through the write port, and `upd` stays low.
- R4: Writing the seconds field restarts the prescaler. The next update comes exactly `TICK_DIV` cycles after the write edge, and no update occurs in between.
- R5: Seconds and minutes count 00 to 59 in BCD. Each wraps to 00 and carries into the next field.
- R6: With hour bit 6 at 0 (24-hour form), hours count 00 to 23 in BCD in bits 5:0. 23 wraps to 00 and carries into the date and the day of week.
- R7: With hour bit 6 at 1 (12-hour form), bit 5 is PM and bits 4:0 hold 01 to 12 in BCD. 11 goes to 12 and toggles PM. 12 goes to 01 and keeps PM. Only the step from 11 PM to 12 AM carries into the date.
- R8: The day of month wraps to 01 after 30 in April, June, September and November, and after 31 in the other months except February. On that wrap the month advances.
- R9: February ends on day 29 when the BCD year is a multiple of 4, including 00, and on day 28 otherwise.
- R10: Day of week counts 1 to 7 and wraps to 1. Month 12 wraps to 01 and advances the year. Year 99 wraps to 00.
- R11: Write port field codes are 0 seconds, 1 minutes, 2 hours, 3 day of week, 4 day of month, 5 month, 6 year. Code 7 changes nothing. Written data is masked to 7F for seconds, minutes and hours, 07 for day of week, 3F for day of month, 1F for month and FF for year.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| osc_en_n | input | 1 | Run control, low lets time advance |
| wr_en | input | 1 | Field write strobe |
| wr_sel | input | 3 | Field code for the write |
| wr_data | input | 8 | BCD value to load |
| sec | output | 8 | Seconds, BCD |
| min | output | 8 | Minutes, BCD |
| hour | output | 8 | Hours with format and PM bits |
| dow | output | 8 | Day of week 1 to 7 |
| date | output | 8 | Day of month, BCD |
| month | output | 8 | Month, BCD |
| year | output | 8 | Year 00 to 99, BCD |
| upd | output | 1 | One-cycle strobe after each update |

## Verification
Most faults in the carry chain stay hidden until a rollover boundary is crossed. A wrong month length, a wrong leap test or a wrong 12-hour transition only shows on the single update that crosses that boundary. For this reason, the bench loads the time one second before each boundary and checks the very next update. A prescaler that fails to restart, or that runs while stopped, moves the update strobe by at least one cycle. The bench catches this by checking the strobe cycle by cycle around a seconds write.

// File: rtl/rtcc_pkg.sv
package rtcc_pkg;

   typedef enum logic [2:0] {
      FLD_SEC   = 3'd0,
      FLD_MIN   = 3'd1,
      FLD_HOUR  = 3'd2,
      FLD_DOW   = 3'd3,
      FLD_DATE  = 3'd4,
      FLD_MONTH = 3'd5,
      FLD_YEAR  = 3'd6,
      FLD_NONE  = 3'd7
   } fld_e;

   // Add one to a two-digit packed BCD value.
   function automatic logic [7:0] bcd_inc(input logic [7:0] v);
      logic [7:0] r;
      if (v[3:0] == 4'd9) r = {v[7:4] + 4'd1, 4'd0};
      else                r = {v[7:4], v[3:0] + 4'd1};
      return r;
   endfunction

   // A BCD year is a multiple of four when an even tens digit
   // pairs with units 0/4/8, or an odd tens digit with units 2/6.
   function automatic logic leap_yr(input logic [7:0] y);
      logic r;
      if (!y[4]) r = (y[3:0] == 4'd0) || (y[3:0] == 4'd4) || (y[3:0] == 4'd8);
      else       r = (y[3:0] == 4'd2) || (y[3:0] == 4'd6);
      return r;
   endfunction

   // Last day of a BCD month.
   function automatic logic [7:0] month_len(input logic [7:0] m, input logic leap);
      logic [7:0] r;
      case (m)
         8'h02:                      r = leap ? 8'h29 : 8'h28;
         8'h04, 8'h06, 8'h09, 8'h11: r = 8'h30;
         default:                    r = 8'h31;
      endcase
      return r;
   endfunction

endpackage

// File: rtl/rtcc_prescaler.sv
module rtcc_prescaler #(
   parameter int TICK_DIV = 32768
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   input  logic clr,
   output logic tick
);
   localparam int CW = (TICK_DIV > 2) ? $clog2(TICK_DIV) : 1;
   localparam logic [CW-1:0] LAST = CW'(TICK_DIV - 1);

   logic [CW-1:0] cnt;

   assign tick = run && !clr && (cnt == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   cnt <= '0;
      else if (clr) cnt <= '0;
      else if (run) cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
   end
endmodule

// File: rtl/rtcc_bcd_wrap.sv
module rtcc_bcd_wrap #(
   parameter logic [7:0] LO   = 8'h00,
   parameter logic [7:0] HI   = 8'h59,
   parameter logic [7:0] MASK = 8'h7F,
   parameter logic [7:0] INIT = 8'h00
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       inc,
   input  logic       ld,
   input  logic [7:0] ld_val,
   output logic [7:0] val,
   output logic       carry
);
   import rtcc_pkg::*;

   assign carry = inc && !ld && (val == HI);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   val <= INIT;
      else if (ld)  val <= ld_val & MASK;
      else if (inc) val <= (val == HI) ? LO : bcd_inc(val);
   end
endmodule

// File: rtl/rtcc_hour.sv
module rtcc_hour (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       inc,
   input  logic       ld,
   input  logic [7:0] ld_val,
   output logic [7:0] hour,
   output logic       day_cy
);
   import rtcc_pkg::*;

   logic [7:0] nxt;
   logic       wrap;
   logic [7:0] step;

   always_comb begin
      wrap = 1'b0;
      step = '0;
      if (hour[6]) begin
         step = bcd_inc({3'b000, hour[4:0]});
         if (hour[4:0] == 5'h12) begin
            nxt = {2'b01, hour[5], 5'h01};
         end else if (hour[4:0] == 5'h11) begin
            nxt  = {2'b01, ~hour[5], 5'h12};
            wrap = hour[5];
         end else begin
            nxt = {2'b01, hour[5], step[4:0]};
         end
      end else begin
         step = bcd_inc({2'b00, hour[5:0]});
         if (hour[5:0] == 6'h23) begin
            nxt  = 8'h00;
            wrap = 1'b1;
         end else begin
            nxt = {2'b00, step[5:0]};
         end
      end
   end

   assign day_cy = inc && !ld && wrap;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   hour <= 8'h00;
      else if (ld)  hour <= ld_val & 8'h7F;
      else if (inc) hour <= nxt;
   end
endmodule

// File: rtl/rtcc_calendar.sv
module rtcc_calendar (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       inc,
   input  logic       ld_date,
   input  logic       ld_month,
   input  logic [7:0] ld_val,
   input  logic [7:0] year,
   output logic [7:0] date,
   output logic [7:0] month,
   output logic       yr_cy
);
   import rtcc_pkg::*;

   logic [7:0] last_day;
   logic       end_of_month;

   assign last_day     = month_len(month, leap_yr(year));
   assign end_of_month = inc && !ld_date && (date == last_day);
   assign yr_cy        = end_of_month && !ld_month && (month == 8'h12);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       date <= 8'h01;
      else if (ld_date) date <= ld_val & 8'h3F;
      else if (inc)     date <= (date == last_day) ? 8'h01 : bcd_inc(date);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            month <= 8'h01;
      else if (ld_month)     month <= ld_val & 8'h1F;
      else if (end_of_month) month <= (month == 8'h12) ? 8'h01 : bcd_inc(month);
   end
endmodule

// File: rtl/bcd_calendar_clock.sv
module bcd_calendar_clock #(
   parameter int TICK_DIV = 32768
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       osc_en_n,
   input  logic       wr_en,
   input  logic [2:0] wr_sel,
   input  logic [7:0] wr_data,
   output logic [7:0] sec,
   output logic [7:0] min,
   output logic [7:0] hour,
   output logic [7:0] dow,
   output logic [7:0] date,
   output logic [7:0] month,
   output logic [7:0] year,
   output logic       upd
);
   import rtcc_pkg::*;

   generate
      if (TICK_DIV < 2) begin : g_bad_div
         $error("TICK_DIV must be at least 2");
      end
   endgenerate

   logic ld_sec, ld_min, ld_hour, ld_dow, ld_date, ld_month, ld_year;
   logic tick, sec_cy, min_cy, day_cy, yr_cy, dow_cy, year_cy;

   assign ld_sec   = wr_en && (wr_sel == FLD_SEC);
   assign ld_min   = wr_en && (wr_sel == FLD_MIN);
   assign ld_hour  = wr_en && (wr_sel == FLD_HOUR);
   assign ld_dow   = wr_en && (wr_sel == FLD_DOW);
   assign ld_date  = wr_en && (wr_sel == FLD_DATE);
   assign ld_month = wr_en && (wr_sel == FLD_MONTH);
   assign ld_year  = wr_en && (wr_sel == FLD_YEAR);

   rtcc_prescaler #(.TICK_DIV(TICK_DIV)) u_pre (
      .clk(clk), .rst_n(rst_n), .run(!osc_en_n), .clr(ld_sec), .tick(tick)
   );

   rtcc_bcd_wrap #(.LO(8'h00), .HI(8'h59), .MASK(8'h7F), .INIT(8'h00)) u_sec (
      .clk(clk), .rst_n(rst_n), .inc(tick), .ld(ld_sec), .ld_val(wr_data),
      .val(sec), .carry(sec_cy)
   );

   rtcc_bcd_wrap #(.LO(8'h00), .HI(8'h59), .MASK(8'h7F), .INIT(8'h00)) u_min (
      .clk(clk), .rst_n(rst_n), .inc(sec_cy), .ld(ld_min), .ld_val(wr_data),
      .val(min), .carry(min_cy)
   );

   rtcc_hour u_hour (
      .clk(clk), .rst_n(rst_n), .inc(min_cy), .ld(ld_hour), .ld_val(wr_data),
      .hour(hour), .day_cy(day_cy)
   );

   rtcc_bcd_wrap #(.LO(8'h01), .HI(8'h07), .MASK(8'h07), .INIT(8'h01)) u_dow (
      .clk(clk), .rst_n(rst_n), .inc(day_cy), .ld(ld_dow), .ld_val(wr_data),
      .val(dow), .carry(dow_cy)
   );

   rtcc_calendar u_cal (
      .clk(clk), .rst_n(rst_n), .inc(day_cy), .ld_date(ld_date),
      .ld_month(ld_month), .ld_val(wr_data), .year(year),
      .date(date), .month(month), .yr_cy(yr_cy)
   );

   rtcc_bcd_wrap #(.LO(8'h00), .HI(8'h99), .MASK(8'hFF), .INIT(8'h00)) u_year (
      .clk(clk), .rst_n(rst_n), .inc(yr_cy), .ld(ld_year), .ld_val(wr_data),
      .val(year), .carry(year_cy)
   );

   logic unused_cy;
   assign unused_cy = dow_cy ^ year_cy;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) upd <= 1'b0;
      else        upd <= tick;
   end
endmodule

// File: rtl/rtcc_checker.sv
module rtcc_checker (
   input logic       clk,
   input logic       rst_n,
   input logic       osc_en_n,
   input logic       wr_en,
   input logic [2:0] wr_sel,
   input logic [7:0] sec,
   input logic [7:0] min,
   input logic [7:0] hour,
   input logic [7:0] dow,
   input logic [7:0] date,
   input logic [7:0] month,
   input logic [7:0] year,
   input logic       upd
);
   // An update strobe is at most one cycle wide (TICK_DIV >= 2).
   p_upd_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
      upd |=> !upd);

   // Every update moves the seconds field.
   p_upd_moves_sec_r2: assert property (@(posedge clk) disable iff (!rst_n)
      upd |-> (sec != $past(sec)));

   // A stopped prescaler yields no update in the next cycle.
   p_no_upd_stopped_r3: assert property (@(posedge clk) disable iff (!rst_n)
      osc_en_n |=> !upd);

   // Stopped and not written: every field holds.
   p_hold_stopped_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (osc_en_n && !wr_en) |=> ($stable(sec) && $stable(min) && $stable(hour) &&
                                $stable(dow) && $stable(date) && $stable(month) &&
                                $stable(year)));

   // A seconds write is never followed directly by an update.
   p_sec_write_restarts_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_sel == 3'd0) |=> !upd);

   // Day of week stays in 1..7 once there, unless rewritten.
   p_dow_range_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_en && dow >= 8'h01 && dow <= 8'h07) |=> (dow >= 8'h01 && dow <= 8'h07));

   // Month never becomes zero from a nonzero value without a write.
   p_month_nonzero_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_en && month != 8'h00) |=> (month != 8'h00));
endmodule

bind bcd_calendar_clock rtcc_checker u_rtcc_checker (
   .clk(clk), .rst_n(rst_n), .osc_en_n(osc_en_n), .wr_en(wr_en), .wr_sel(wr_sel),
   .sec(sec), .min(min), .hour(hour), .dow(dow), .date(date), .month(month),
   .year(year), .upd(upd)
);

// File: tb/bcd_calendar_clock_bench.sv
module bcd_calendar_clock_bench;
   localparam int DIV = 4;
   localparam int NV  = 18;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       osc_en_n = 1'b1;
   logic       wr_en = 1'b0;
   logic [2:0] wr_sel = 3'd0;
   logic [7:0] wr_data = 8'h00;
   logic [7:0] sec, min, hour, dow, date, month, year;
   logic       upd;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   bcd_calendar_clock #(.TICK_DIV(DIV)) u_bcd_calendar_clock (
      .clk(clk), .rst_n(rst_n), .osc_en_n(osc_en_n), .wr_en(wr_en),
      .wr_sel(wr_sel), .wr_data(wr_data), .sec(sec), .min(min), .hour(hour),
      .dow(dow), .date(date), .month(month), .year(year), .upd(upd)
   );

   // {sec,min,hour,dow,date,month,year} loaded, then expected after one update.
   localparam logic [111:0] VEC [NV] = '{
      {56'h56_34_12_03_15_06_21, 56'h57_34_12_03_15_06_21}, // R5 plain step
      {56'h59_09_08_03_15_06_21, 56'h00_10_08_03_15_06_21}, // R5 minute carry
      {56'h59_59_09_03_15_06_21, 56'h00_00_10_03_15_06_21}, // R6 09 -> 10
      {56'h59_59_19_03_15_06_21, 56'h00_00_20_03_15_06_21}, // R6 19 -> 20
      {56'h59_59_23_07_31_12_99, 56'h00_00_00_01_01_01_00}, // R10 full wrap
      {56'h59_59_23_02_28_02_24, 56'h00_00_00_03_29_02_24}, // R9 leap 24
      {56'h59_59_23_02_28_02_23, 56'h00_00_00_03_01_03_23}, // R9 common 23
      {56'h59_59_23_04_29_02_00, 56'h00_00_00_05_01_03_00}, // R9 leap 00 end
      {56'h59_59_23_01_30_04_21, 56'h00_00_00_02_01_05_21}, // R8 April
      {56'h59_59_23_01_30_09_21, 56'h00_00_00_02_01_10_21}, // R8 September
      {56'h59_59_23_01_30_01_21, 56'h00_00_00_02_31_01_21}, // R8 January 30
      {56'h59_59_71_05_15_06_21, 56'h00_00_52_06_16_06_21}, // R7 11PM -> 12AM
      {56'h59_59_51_05_15_06_21, 56'h00_00_72_05_15_06_21}, // R7 11AM -> 12PM
      {56'h59_59_72_05_15_06_21, 56'h00_00_61_05_15_06_21}, // R7 12PM -> 01PM
      {56'h59_59_49_05_15_06_21, 56'h00_00_50_05_15_06_21}, // R7 09AM -> 10AM
      {56'h59_59_23_01_28_02_32, 56'h00_00_00_02_29_02_32}, // R9 odd tens leap
      {56'h59_59_23_01_28_02_30, 56'h00_00_00_02_01_03_30}, // R9 30 common
      {56'h59_59_23_06_31_12_41, 56'h00_00_00_07_01_01_42}  // R10 year step
   };
   localparam int VTAG [NV] = '{5, 5, 6, 6, 10, 9, 9, 9, 8, 8, 8, 7, 7, 7, 7, 9, 9, 10};

   task automatic chk(input string tag, input string what,
                      input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] s, input logic [7:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_sel = s; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic load_all(input logic [55:0] t);
      wr(3'd6, t[7:0]);   wr(3'd5, t[15:8]);  wr(3'd4, t[23:16]);
      wr(3'd3, t[31:24]); wr(3'd2, t[39:32]); wr(3'd1, t[47:40]);
      wr(3'd0, t[55:48]);
   endtask

   task automatic cmp_all(input string tag, input logic [55:0] e);
      chk(tag, "sec", sec, e[55:48]);   chk(tag, "min", min, e[47:40]);
      chk(tag, "hour", hour, e[39:32]); chk(tag, "dow", dow, e[31:24]);
      chk(tag, "date", date, e[23:16]); chk(tag, "month", month, e[15:8]);
      chk(tag, "year", year, e[7:0]);
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin : main
      logic [55:0] snap;
      bit seen;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset values
      cmp_all("R1", 56'h00_00_00_01_01_01_00);
      chk("R1", "upd", {7'd0, upd}, 8'h00);

      // R3 stopped: nothing moves, no strobe
      seen = 1'b0;
      for (int k = 0; k < 4 * DIV; k++) begin
         @(negedge clk);
         if (upd) seen = 1'b1;
      end
      chk("R3", "upd seen", {7'd0, seen}, 8'h00);
      cmp_all("R3", 56'h00_00_00_01_01_01_00);

      // R11 masking and ignored code
      wr(3'd0, 8'hFF); chk("R11", "sec mask", sec, 8'h7F);
      wr(3'd2, 8'hE5); chk("R11", "hour mask", hour, 8'h65);
      wr(3'd3, 8'hFE); chk("R11", "dow mask", dow, 8'h06);
      wr(3'd4, 8'hFF); chk("R11", "date mask", date, 8'h3F);
      wr(3'd5, 8'hFF); chk("R11", "month mask", month, 8'h1F);
      wr(3'd6, 8'hFF); chk("R11", "year mask", year, 8'hFF);
      snap = {sec, min, hour, dow, date, month, year};
      wr(3'd7, 8'h12);
      cmp_all("R11", snap);

      // R4 seconds write restarts prescaler, R2 period
      load_all(56'h10_00_00_01_01_01_00);
      osc_en_n = 1'b0;
      repeat (2) @(negedge clk);
      wr(3'd0, 8'h30);
      for (int k = 1; k < DIV; k++) begin
         @(negedge clk);
         chk("R4", "upd early", {7'd0, upd}, 8'h00);
         chk("R4", "sec held", sec, 8'h30);
      end
      @(negedge clk);
      chk("R4", "upd on time", {7'd0, upd}, 8'h01);
      chk("R4", "sec step", sec, 8'h31);
      for (int k = 1; k < DIV; k++) begin
         @(negedge clk);
         chk("R2", "upd gap", {7'd0, upd}, 8'h00);
      end
      @(negedge clk);
      chk("R2", "upd period", {7'd0, upd}, 8'h01);
      chk("R2", "sec period", sec, 8'h32);
      osc_en_n = 1'b1;

      // Rollover vectors
      for (int v = 0; v < NV; v++) begin
         string tag;
         tag = $sformatf("R%0d v%0d", VTAG[v], v);
         osc_en_n = 1'b1;
         load_all(VEC[v][111:56]);
         osc_en_n = 1'b0;
         seen = 1'b0;
         for (int k = 0; k < 4 * DIV && !seen; k++) begin
            @(negedge clk);
            if (upd) seen = 1'b1;
         end
         chk(tag, "upd", {7'd0, seen}, 8'h01);
         cmp_all(tag, VEC[v][55:0]);
         @(negedge clk);
         chk(tag, "upd width", {7'd0, upd}, 8'h00);
         osc_en_n = 1'b1;
      end

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule